// File: doc/BRIEF.md
# Display Pipe Control Sequencer

This block holds the control and sequencing logic for one display pipe. It sits next to a horizontal and vertical timing generator. A set of configuration inputs drives it: a pipe enable, a two-bit frame-start delay, a three-bit scan-mode field, a force-border test bit and one enable request per plane. The timing generator sends back an HBLANK strobe, which is high for one cycle per line, and a VBLANK level. The block decides when the timing generator runs and reports the real pipe state. It sends one frame-start pulse per frame to the planes, placed a programmable number of HBLANKs after vertical blank begins. It also keeps plane-disable and scan-mode changes back until a vertical-blank boundary while the pipe is running.

A three-state machine controls the pipe:
- `PS_OFF`: the timing generator is halted.
- `PS_RUN`: the pipe is running normally.
- `PS_DRAIN`: enable has been cleared, but the current frame is still being finished.

The machine has four transitions:
- *start*: `PS_OFF`→`PS_RUN` when enable is seen high.
- *drain*: `PS_RUN`→`PS_DRAIN` when enable is seen low.
- *resume*: `PS_DRAIN`→`PS_RUN` when enable returns before the next vertical blank.
- *halt*: `PS_DRAIN`→`PS_OFF` on the cycle where VBLANK rises.

A VBLANK start is a cycle where `tg_vblank` is high and it was low in the previous cycle.

Top module: `pipe_ctl_seq`

## Requirements
- R1: While the pipe is off, `cfg_enable` sampled high makes `tg_run` and `pipe_state` go to 1 after the next clock edge (*start*).
- R2: After `cfg_enable` is cleared, `tg_run` and `pipe_state` stay 1 until a VBLANK start. Both then fall together after that cycle's edge (*halt*). If enable returns before then, the pipe keeps running (*resume*).
- R3: `cfg_fs_delay` = N (0..3) picks the (N+1)-th HBLANK strobe seen while VBLANK is high, counting from the VBLANK start cycle itself. That strobe raises `frame_start` for one cycle, one cycle later. A strobe that falls in the VBLANK start cycle is counted as the first.
- R4: If VBLANK falls before the selected strobe arrives, no frame-start pulse is issued for that frame. The count starts again at the next VBLANK start.
- R5: At most one `frame_start` pulse is issued per frame, and it is one cycle wide. No pulse is issued while the pipe is off, nor for the vertical blank that halts the pipe.
- R6: While `pipe_state` is 0, `plane_en` is all zero, whatever `cfg_plane_req` holds.
- R7: While the pipe runs, a set request bit raises its `plane_en` bit one cycle later. A cleared request bit drops its `plane_en` bit only after the next VBLANK start. All bits drop together with `pipe_state` at *halt*.
- R8: While the pipe is off, `scan_mode` follows `cfg_scan_mode` after one edge. While the pipe runs, `scan_mode` changes only by loading `cfg_scan_mode` at a VBLANK start.
- R9: `scan_ilace` is bit 2 of `scan_mode`. Codes 0xx mean progressive. Codes 100, 101, 110 and 111 are forwarded unchanged as distinct interlaced variants.
- R10: `border_sel` is 1 exactly when `cfg_force_border` is 1, the pipe is on and `tg_vblank` is 0 (the active region).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Pipe enable request |
| cfg_fs_delay | input | FS_W | Frame-start HBLANK index minus one |
| cfg_scan_mode | input | MODE_W | Requested scan mode |
| cfg_force_border | input | 1 | Substitute border colour in active region |
| cfg_plane_req | input | NPL | Per-plane enable requests |
| tg_hblank | input | 1 | HBLANK strobe, one cycle per line |
| tg_vblank | input | 1 | VBLANK level |
| tg_run | output | 1 | Timing generator run |
| pipe_state | output | 1 | True pipe state |
| frame_start | output | 1 | Frame-start pulse to planes |
| plane_en | output | NPL | Effective plane enables |
| scan_mode | output | MODE_W | Active scan mode |
| scan_ilace | output | 1 | Active mode is interlaced |
| border_sel | output | 1 | Border-substitute select |

## Verification
Two events can land in the same cycle: the VBLANK start that clears and arms the HBLANK counter, and an HBLANK strobe that must be counted. The bench drives both in one cycle with delay 0 and expects a pulse on the next cycle, followed by silence for the rest of that frame. A second overlap is the *halt* event arriving together with a strobe that would otherwise trigger a delay-0 frame start. There the bench expects the pipe to drop with no pulse.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;
    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_RUN   = 2'd1,
        PS_DRAIN = 2'd2
    } pipe_st_e;
endpackage

// File: rtl/pipe_run_fsm.sv
module pipe_run_fsm
    import pipe_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic vb_start,
    output logic run_on,
    output logic arm_ok,
    output logic stop_evt
);
    pipe_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_OFF:   if (enable) st_d = PS_RUN;
            PS_RUN:   if (!enable) st_d = PS_DRAIN;
            PS_DRAIN: begin
                if (enable)        st_d = PS_RUN;
                else if (vb_start) st_d = PS_OFF;
            end
            default:  st_d = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        run_on   = 1'b0;
        arm_ok   = 1'b0;
        stop_evt = 1'b0;
        unique case (st_q)
            PS_OFF:   ;
            PS_RUN:   begin run_on = 1'b1; arm_ok = 1'b1; end
            PS_DRAIN: begin run_on = 1'b1; stop_evt = vb_start && !enable; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/fstart_gen.sv
module fstart_gen #(
    parameter int FS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_on,
    input  logic            arm_ok,
    input  logic            vb_start,
    input  logic            vblank,
    input  logic            hblank,
    input  logic [FS_W-1:0] delay,
    output logic            pulse
);
    logic [FS_W-1:0] cnt_q;
    logic            armed_q;
    logic            hit;

    always_comb begin
        if (vb_start) hit = arm_ok && hblank && (delay == '0);
        else          hit = armed_q && vblank && hblank && (cnt_q == delay);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            pulse   <= 1'b0;
        end else begin
            pulse <= hit;
            if (!run_on) begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end else if (vb_start) begin
                armed_q <= arm_ok && !hit;
                cnt_q   <= hblank ? FS_W'(1) : '0;
            end else if (!vblank) begin
                armed_q <= 1'b0;
            end else if (armed_q && hblank) begin
                if (cnt_q == delay) armed_q <= 1'b0;
                else                cnt_q   <= cnt_q + FS_W'(1);
            end
        end
    end
endmodule

// File: rtl/plane_mode_gate.sv
module plane_mode_gate #(
    parameter int NPL    = 3,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_on,
    input  logic              stop_evt,
    input  logic              vb_start,
    input  logic              vblank,
    input  logic [NPL-1:0]    req,
    input  logic [MODE_W-1:0] mode_req,
    input  logic              force_border,
    output logic [NPL-1:0]    plane_en,
    output logic [MODE_W-1:0] mode_act,
    output logic              border
);
    for (genvar p = 0; p < NPL; p++) begin : g_plane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  plane_en[p] <= 1'b0;
            else if (!run_on || stop_evt) plane_en[p] <= 1'b0;
            else if (req[p])             plane_en[p] <= 1'b1;
            else if (vb_start)           plane_en[p] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   mode_act <= '0;
        else if (!run_on || vb_start) mode_act <= mode_req;
    end

    assign border = force_border && run_on && !vblank;
endmodule

// File: rtl/pipe_ctl_seq.sv
module pipe_ctl_seq #(
    parameter int NPL    = 3,
    parameter int FS_W   = 2,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [FS_W-1:0]   cfg_fs_delay,
    input  logic [MODE_W-1:0] cfg_scan_mode,
    input  logic              cfg_force_border,
    input  logic [NPL-1:0]    cfg_plane_req,
    input  logic              tg_hblank,
    input  logic              tg_vblank,
    output logic              tg_run,
    output logic              pipe_state,
    output logic              frame_start,
    output logic [NPL-1:0]    plane_en,
    output logic [MODE_W-1:0] scan_mode,
    output logic              scan_ilace,
    output logic              border_sel
);
    localparam int ILACE_BIT = MODE_W - 1;

    logic vb_q, vb_start, run_on, arm_ok, stop_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vb_q <= 1'b0;
        else        vb_q <= tg_vblank;
    end
    assign vb_start = tg_vblank && !vb_q;

    pipe_run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .vb_start(vb_start),
        .run_on(run_on), .arm_ok(arm_ok), .stop_evt(stop_evt)
    );

    fstart_gen #(.FS_W(FS_W)) u_fs (
        .clk(clk), .rst_n(rst_n), .run_on(run_on), .arm_ok(arm_ok),
        .vb_start(vb_start), .vblank(tg_vblank), .hblank(tg_hblank),
        .delay(cfg_fs_delay), .pulse(frame_start)
    );

    plane_mode_gate #(.NPL(NPL), .MODE_W(MODE_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .run_on(run_on), .stop_evt(stop_evt),
        .vb_start(vb_start), .vblank(tg_vblank), .req(cfg_plane_req),
        .mode_req(cfg_scan_mode), .force_border(cfg_force_border),
        .plane_en(plane_en), .mode_act(scan_mode), .border(border_sel)
    );

    assign tg_run     = run_on;
    assign pipe_state = run_on;
    assign scan_ilace = scan_mode[ILACE_BIT];
endmodule

// File: rtl/pipe_ctl_seq_chk.sv
module pipe_ctl_seq_chk #(
    parameter int NPL    = 3,
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              tg_vblank,
    input logic              tg_run,
    input logic              pipe_state,
    input logic              frame_start,
    input logic [NPL-1:0]    plane_en,
    input logic [MODE_W-1:0] scan_mode
);
    a_r1_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tg_run) |-> $past(cfg_enable));

    a_r2_halt_at_vblank: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pipe_state) |-> ($past(tg_vblank) && !$past(cfg_enable)));

    a_r2_run_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
        tg_run == pipe_state);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    a_r5_no_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_state |-> !frame_start);

    a_r6_planes_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_state |-> (plane_en == '0));

    a_r7_drop_in_vblank: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(plane_en) & ~plane_en)) |-> $past(tg_vblank));

    a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pipe_state) && !$past(tg_vblank)) |-> $stable(scan_mode));
endmodule

bind pipe_ctl_seq pipe_ctl_seq_chk #(.NPL(NPL), .MODE_W(MODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .tg_vblank(tg_vblank),
    .tg_run(tg_run), .pipe_state(pipe_state), .frame_start(frame_start),
    .plane_en(plane_en), .scan_mode(scan_mode)
);

// File: tb/pipe_ctl_seq_tb_top.sv
`timescale 1ns/1ps
module pipe_ctl_seq_tb_top;
    localparam int NPL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0;
    logic [1:0] cfg_fs_delay = 2'd0;
    logic [2:0] cfg_scan_mode = 3'd0;
    logic cfg_force_border = 1'b0;
    logic [NPL-1:0] cfg_plane_req = '0;
    logic tg_hblank = 1'b0;
    logic tg_vblank = 1'b0;
    logic tg_run, pipe_state, frame_start, scan_ilace, border_sel;
    logic [NPL-1:0] plane_en;
    logic [2:0] scan_mode;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pipe_ctl_seq #(.NPL(NPL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_fs_delay(cfg_fs_delay),
        .cfg_scan_mode(cfg_scan_mode), .cfg_force_border(cfg_force_border),
        .cfg_plane_req(cfg_plane_req), .tg_hblank(tg_hblank), .tg_vblank(tg_vblank),
        .tg_run(tg_run), .pipe_state(pipe_state), .frame_start(frame_start),
        .plane_en(plane_en), .scan_mode(scan_mode), .scan_ilace(scan_ilace),
        .border_sel(border_sel)
    );

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // One vertical blank with nhb strobes; exp_idx is the strobe index that must pulse (-1: none)
    task automatic fs_frame(input int d, input int nhb, input int exp_idx, input string req);
        int seen = 0;
        int at = -1;
        cfg_fs_delay = 2'(d);
        tg_vblank = 1'b1; tg_hblank = 1'b0;
        step(); if (frame_start) seen++;
        for (int i = 0; i < nhb; i++) begin
            tg_hblank = 1'b1; step();
            if (frame_start) begin seen++; at = i; end
            tg_hblank = 1'b0; step(); if (frame_start) seen++;
            step(); if (frame_start) seen++;
        end
        tg_vblank = 1'b0; step(); if (frame_start) seen++;
        idle(3);
        check({req, " pulse index"}, at, exp_idx);
        check({req, " pulse count"}, seen, (exp_idx < 0) ? 0 : 1);
    endtask

    task automatic t_reset();
        check("R1 reset tg_run", int'(tg_run), 0);
        check("R6 reset plane_en", int'(plane_en), 0);
        check("R5 reset frame_start", int'(frame_start), 0);
    endtask

    task automatic t_off_behaviour();
        cfg_plane_req = 3'b111; cfg_scan_mode = 3'b101; cfg_force_border = 1'b1;
        step();
        check("R6 request ignored while off", int'(plane_en), 0);
        check("R8 mode immediate when off", int'(scan_mode), 5);
        check("R9 interlace flag for 101", int'(scan_ilace), 1);
        check("R10 no border while off", int'(border_sel), 0);
        cfg_plane_req = '0;
        step();
    endtask

    task automatic t_start();
        cfg_enable = 1'b1;
        check("R1 not yet running", int'(tg_run), 0);
        step();
        check("R1 tg_run after edge", int'(tg_run), 1);
        check("R1 pipe_state after edge", int'(pipe_state), 1);
        check("R10 border in active region", int'(border_sel), 1);
        tg_vblank = 1'b1; #1;
        check("R10 border off in vblank", int'(border_sel), 0);
        tg_vblank = 1'b0; cfg_force_border = 1'b0;
        idle(2);
    endtask

    task automatic t_frame_delays();
        fs_frame(0, 4, 0, "R3 delay 0");
        fs_frame(1, 4, 1, "R3 delay 1");
        fs_frame(2, 4, 2, "R3 delay 2");
        fs_frame(3, 4, 3, "R3 delay 3");
        fs_frame(3, 2, -1, "R4 short vblank");
        fs_frame(3, 4, 3, "R4 count restarted");
    endtask

    task automatic t_coincide();
        int extra = 0;
        cfg_fs_delay = 2'd0;
        tg_vblank = 1'b1; tg_hblank = 1'b1;
        step();
        tg_hblank = 1'b0;
        check("R3 strobe on vblank start counts", int'(frame_start), 1);
        step();
        check("R5 pulse is one cycle", int'(frame_start), 0);
        for (int i = 0; i < 3; i++) begin
            tg_hblank = 1'b1; step(); if (frame_start) extra++;
            tg_hblank = 1'b0; step(); if (frame_start) extra++;
        end
        check("R5 one pulse per frame", extra, 0);
        tg_vblank = 1'b0; idle(3);
    endtask

    task automatic t_planes_mode();
        cfg_plane_req = 3'b111; cfg_scan_mode = 3'b010;
        step();
        check("R7 planes rise next cycle", int'(plane_en), 7);
        check("R8 mode held while running", int'(scan_mode), 5);
        cfg_plane_req = 3'b110;
        idle(3);
        check("R7 plane held until vblank", int'(plane_en), 7);
        tg_vblank = 1'b1;
        step();
        check("R7 plane drops after vblank start", int'(plane_en), 6);
        check("R8 mode loaded at vblank", int'(scan_mode), 2);
        check("R9 progressive flag for 010", int'(scan_ilace), 0);
        tg_vblank = 1'b0; idle(2);
    endtask

    task automatic t_stop();
        cfg_enable = 1'b0; cfg_fs_delay = 2'd0;
        idle(4);
        check("R2 still running while draining", int'(pipe_state), 1);
        cfg_enable = 1'b1; step(); cfg_enable = 1'b0; step();
        check("R2 resume keeps running", int'(tg_run), 1);
        idle(2);
        tg_vblank = 1'b1; tg_hblank = 1'b1;
        check("R2 running before halt edge", int'(pipe_state), 1);
        step();
        tg_hblank = 1'b0;
        check("R2 pipe_state falls at halt", int'(pipe_state), 0);
        check("R2 tg_run falls with state", int'(tg_run), 0);
        check("R5 no pulse at halting vblank", int'(frame_start), 0);
        check("R7 planes drop at halt", int'(plane_en), 0);
        step();
        check("R5 no pulse after halt", int'(frame_start), 0);
        tg_vblank = 1'b0;
        cfg_scan_mode = 3'b110; step();
        check("R9 mode 110 forwarded when off", int'(scan_mode), 6);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        step();
        t_off_behaviour();
        t_start();
        t_frame_delays();
        t_coincide();
        t_planes_mode();
        t_stop();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule